// File: doc/BRIEF.md
# Receive Destination Address Filter

The block watches the bytes of each received Ethernet frame as they stream past and decides whether the frame may enter the receive buffer. It captures the first twelve header octets, which are the destination address and the source address. While the destination octets arrive, it runs a CRC-32 over them. When the frame ends, it combines the address class (broadcast, multicast or unicast), the error flags that came with the last byte, and a set of configuration enables into one accept or drop verdict.

The verdict appears one cycle after the end-of-frame byte, marked by a single-cycle `dec_valid` pulse, and `dec_accept` keeps that verdict until the next start-of-frame byte is taken. Configuration inputs are static while a frame is being judged.

The control is a state machine with six states:
- `ST_IDLE`: after reset.
- `ST_DEST`: collecting destination octets.
- `ST_SRC`: collecting source octets.
- `ST_BODY`: payload.
- `ST_EVAL`: the decision cycle.
- `ST_HOLD`: holding the verdict.

Its transitions are:
- Any state goes to `ST_DEST` on a start byte, or to `ST_EVAL` if that byte also ends the frame.
- `ST_DEST` goes to `ST_SRC` after the sixth octet.
- `ST_SRC` goes to `ST_BODY` after the twelfth octet.
- `ST_DEST`, `ST_SRC` and `ST_BODY` go to `ST_EVAL` on an end byte.
- `ST_EVAL` always goes to `ST_HOLD`.
- `ST_IDLE` and `ST_HOLD` wait for a start byte.

Top module: `rx_da_filter`

## Requirements
- R1: After reset, `dec_valid` and `dec_accept` are both 0.
- R2: `dec_valid` is high for exactly the one cycle after the clock edge that takes a byte with `in_eof` set. `dec_accept` carries the verdict in that cycle and keeps it until the edge that takes the next `in_sof` byte, after which it reads 0.
- R3: With `cfg_pass_all` set, every completed frame is accepted, whatever its length, address or error flags.
- R4: The flags `in_crc_err`, `in_len_err` and `in_range_err` are sampled with the end byte. A frame with a flag set is dropped unless the matching `cfg_pass_crc`, `cfg_pass_len` or `cfg_pass_range` bit is set.
- R5: A frame whose six destination octets are all 0xFF is broadcast. It is accepted only when `cfg_bcast_en` is set.
- R6: A frame whose first destination octet has bit 0 clear is unicast. It is dropped when `cfg_ucast_en` is 0. With `cfg_da_match_en` set, it is accepted only if its destination equals the station address: octets 0..2 are in `station_hi[23:16]`, `[15:8]` and `[7:0]`, and octets 3..5 are in `station_lo` in the same layout. Without `cfg_da_match_en`, any unicast destination passes.
- R7: A non-broadcast frame with bit 0 of its first destination octet set is multicast. It is dropped when `cfg_mcast_en` is 0. With `cfg_hash_en` set, it is accepted only if the hash table bit is 1:
  - The CRC register starts at all ones.
  - Each of the six destination octets is shifted in LSB first. For each bit, take feedback = reg[0] XOR bit, shift the register right by one, and XOR in 0xEDB88320 when the feedback is 1.
  - The index is the final reg[31:26], not complemented.
  - Index bit 5 selects `hash_hi` (1) or `hash_lo` (0), and index[4:0] selects the bit within it.
- R8: With `cfg_sa_en` set, a frame passes only if its source address (octets 6..11, octet 6 in `sa_ref[47:40]`) equals `sa_ref`. `cfg_sa_invert` reverses this test. A frame shorter than 12 bytes counts as not matching.
- R9: A frame of fewer than 6 bytes is dropped unless `cfg_pass_all` is set. A frame of exactly 6 bytes is judged normally.
- R10: The block ignores:
  - cycles with `in_valid` low;
  - bytes outside a frame, including an `in_eof` without a preceding `in_sof`.
  
  A new `in_sof` in the middle of a frame restarts capture, and the abandoned frame gets no decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Byte strobe |
| in_data | input | 8 | Received byte |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Last byte of a frame |
| in_crc_err | input | 1 | Frame check error, valid with the end byte |
| in_len_err | input | 1 | Length field error, valid with the end byte |
| in_range_err | input | 1 | Length out of range, valid with the end byte |
| cfg_pass_all | input | 1 | Accept every frame |
| cfg_pass_crc | input | 1 | Keep frames with a check error |
| cfg_pass_len | input | 1 | Keep frames with a length error |
| cfg_pass_range | input | 1 | Keep frames out of range |
| cfg_ucast_en | input | 1 | Unicast enable |
| cfg_da_match_en | input | 1 | Compare unicast destination with station address |
| cfg_mcast_en | input | 1 | Multicast enable |
| cfg_hash_en | input | 1 | Filter multicast through the hash table |
| cfg_bcast_en | input | 1 | Broadcast enable |
| cfg_sa_en | input | 1 | Source address compare enable |
| cfg_sa_invert | input | 1 | Reject on source match instead of requiring it |
| station_hi | input | 24 | Station address octets 0..2 |
| station_lo | input | 24 | Station address octets 3..5 |
| hash_hi | input | 32 | Hash table bits 32..63 |
| hash_lo | input | 32 | Hash table bits 0..31 |
| sa_ref | input | 48 | Source address reference |
| dec_valid | output | 1 | Decision strobe |
| dec_accept | output | 1 | Verdict, held until next frame |

## Verification
A corrupted captured octet or CRC register shows up only as a wrong `dec_accept` in the decision cycle of the affected frame, so each address class is driven with frames that differ from an accepted one in a single octet. A state machine stuck in or skipping a state shows up as a missing or doubled `dec_valid` pulse, or a `dec_accept` that moves outside the decision cycle and the start-of-frame edge. These faults are visible within one frame. Restarted frames and stray end bytes are used to expose pulses that appear without cause.

// File: rtl/rx_daf_pkg.sv
package rx_daf_pkg;

    localparam int OCTET_W     = 8;
    localparam int ADDR_OCTETS = 6;
    localparam int HDR_OCTETS  = 2 * ADDR_OCTETS;
    localparam int ADDR_W      = OCTET_W * ADDR_OCTETS;
    localparam int CNT_W       = $clog2(HDR_OCTETS + 1);
    localparam int HASH_IDX_W  = 6;
    localparam int HASH_HALF_W = 2 ** (HASH_IDX_W - 1);
    localparam int CRC_W       = 32;
    localparam logic [CRC_W-1:0] CRC_POLY = 32'hEDB88320;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEST,
        ST_SRC,
        ST_BODY,
        ST_EVAL,
        ST_HOLD
    } daf_state_e;

    typedef struct packed {
        logic crc;
        logic len;
        logic range;
    } frame_err_t;

    typedef struct packed {
        logic pass_all;
        logic pass_crc;
        logic pass_len;
        logic pass_range;
        logic ucast_en;
        logic da_match_en;
        logic mcast_en;
        logic hash_en;
        logic bcast_en;
        logic sa_en;
        logic sa_invert;
    } daf_cfg_t;

    // Reflected CRC-32 over one octet, least significant bit first.
    function automatic logic [CRC_W-1:0] crc_step_byte(
        input logic [CRC_W-1:0]   cur,
        input logic [OCTET_W-1:0] b
    );
        logic [CRC_W-1:0] r;
        logic fb;
        r = cur;
        for (int i = 0; i < OCTET_W; i++) begin
            fb = r[0] ^ b[i];
            r  = r >> 1;
            if (fb) r = r ^ CRC_POLY;
        end
        return r;
    endfunction

endpackage

// File: rtl/rx_daf_capture.sv
module rx_daf_capture
    import rx_daf_pkg::*;
#(
    parameter int W   = OCTET_W,
    parameter int HDR = HDR_OCTETS,
    localparam int CW = $clog2(HDR + 1),
    localparam int AW = W * (HDR / 2)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take,
    input  logic          start,
    input  logic          eof,
    input  logic [W-1:0]  data,
    input  frame_err_t    err_in,
    output logic [AW-1:0] da,
    output logic [AW-1:0] sa,
    output logic [CW-1:0] cnt,
    output frame_err_t    err_q
);

    logic [W-1:0]  oct_q [HDR];
    logic [CW-1:0] idx;

    assign idx = start ? '0 : cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < HDR; i++) oct_q[i] <= '0;
        end else if (take) begin
            for (int i = 0; i < HDR; i++) begin
                if (idx == CW'(i)) oct_q[i] <= data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= CW'(1);
        end else if (take && (cnt < CW'(HDR))) begin
            cnt <= cnt + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= '0;
        end else if (take) begin
            if (eof)        err_q <= err_in;
            else if (start) err_q <= '0;
        end
    end

    // Octet 0 lands in the top byte of each address vector.
    for (genvar g = 0; g < HDR / 2; g++) begin : g_pack
        assign da[AW-1-g*W -: W] = oct_q[g];
        assign sa[AW-1-g*W -: W] = oct_q[g + HDR/2];
    end

endmodule

// File: rtl/rx_daf_hash.sv
module rx_daf_hash
    import rx_daf_pkg::*;
#(
    parameter int W     = OCTET_W,
    parameter int NOCT  = ADDR_OCTETS,
    parameter int IDX_W = HASH_IDX_W,
    parameter int CW    = CNT_W,
    localparam int HW   = 2 ** (IDX_W - 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take,
    input  logic          start,
    input  logic [CW-1:0] cnt,
    input  logic [W-1:0]  data,
    input  logic [HW-1:0] table_hi,
    input  logic [HW-1:0] table_lo,
    output logic          hit
);

    logic [CRC_W-1:0] crc_q;
    logic [IDX_W-1:0] hidx;
    logic [HW-1:0]    half;
    logic             upd;

    assign upd = take && (start || (cnt < CW'(NOCT)));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_q <= '1;
        end else if (upd) begin
            crc_q <= crc_step_byte(start ? '1 : crc_q, data);
        end
    end

    assign hidx = crc_q[CRC_W-1 -: IDX_W];
    assign half = hidx[IDX_W-1] ? table_hi : table_lo;
    assign hit  = half[hidx[IDX_W-2:0]];

endmodule

// File: rtl/rx_daf_decide.sv
module rx_daf_decide
    import rx_daf_pkg::*;
#(
    parameter int AW   = ADDR_W,
    parameter int CW   = CNT_W,
    parameter int NOCT = ADDR_OCTETS
) (
    input  daf_cfg_t        cfg,
    input  logic [AW-1:0]   da,
    input  logic [AW-1:0]   sa,
    input  logic [AW/2-1:0] st_hi,
    input  logic [AW/2-1:0] st_lo,
    input  logic [AW-1:0]   sa_ref,
    input  logic [CW-1:0]   cnt,
    input  frame_err_t      err,
    input  logic            hash_hit,
    output logic            accept
);

    logic is_bcast, is_mcast, hdr_ok, sa_full, sa_match;
    logic err_block, class_ok, sa_ok;

    always_comb begin
        is_bcast  = &da;
        is_mcast  = da[AW-OCTET_W] && !is_bcast;
        hdr_ok    = cnt >= CW'(NOCT);
        sa_full   = cnt >= CW'(2 * NOCT);
        err_block = (err.crc   && !cfg.pass_crc)
                 || (err.len   && !cfg.pass_len)
                 || (err.range && !cfg.pass_range);
        if (is_bcast)
            class_ok = cfg.bcast_en;
        else if (is_mcast)
            class_ok = cfg.mcast_en && (!cfg.hash_en || hash_hit);
        else
            class_ok = cfg.ucast_en && (!cfg.da_match_en || (da == {st_hi, st_lo}));
        sa_match = sa_full && (sa == sa_ref);
        sa_ok    = !cfg.sa_en || (sa_match ^ cfg.sa_invert);
        accept   = cfg.pass_all || (hdr_ok && !err_block && class_ok && sa_ok);
    end

endmodule

// File: rtl/rx_da_filter.sv
module rx_da_filter
    import rx_daf_pkg::*;
#(
    parameter int W    = OCTET_W,
    parameter int NOCT = ADDR_OCTETS,
    localparam int AW  = W * NOCT,
    localparam int CW  = $clog2(2 * NOCT + 1),
    localparam int HW  = HASH_HALF_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [W-1:0]  in_data,
    input  logic          in_sof,
    input  logic          in_eof,
    input  logic          in_crc_err,
    input  logic          in_len_err,
    input  logic          in_range_err,
    input  logic          cfg_pass_all,
    input  logic          cfg_pass_crc,
    input  logic          cfg_pass_len,
    input  logic          cfg_pass_range,
    input  logic          cfg_ucast_en,
    input  logic          cfg_da_match_en,
    input  logic          cfg_mcast_en,
    input  logic          cfg_hash_en,
    input  logic          cfg_bcast_en,
    input  logic          cfg_sa_en,
    input  logic          cfg_sa_invert,
    input  logic [AW/2-1:0] station_hi,
    input  logic [AW/2-1:0] station_lo,
    input  logic [HW-1:0] hash_hi,
    input  logic [HW-1:0] hash_lo,
    input  logic [AW-1:0] sa_ref,
    output logic          dec_valid,
    output logic          dec_accept
);

    localparam logic [CW-1:0] LAST_DA = CW'(NOCT - 1);
    localparam logic [CW-1:0] LAST_SA = CW'(2 * NOCT - 1);

    daf_state_e    state, nxt;
    daf_cfg_t      cfg;
    frame_err_t    err_in, err_q;
    logic [AW-1:0] da, sa;
    logic [CW-1:0] cnt;
    logic          start, in_frame, take, hash_hit, decide, accept_q;

    assign cfg = '{pass_all: cfg_pass_all, pass_crc: cfg_pass_crc,
                   pass_len: cfg_pass_len, pass_range: cfg_pass_range,
                   ucast_en: cfg_ucast_en, da_match_en: cfg_da_match_en,
                   mcast_en: cfg_mcast_en, hash_en: cfg_hash_en,
                   bcast_en: cfg_bcast_en, sa_en: cfg_sa_en,
                   sa_invert: cfg_sa_invert};
    assign err_in   = '{crc: in_crc_err, len: in_len_err, range: in_range_err};
    assign start    = in_valid && in_sof;
    assign in_frame = (state == ST_DEST) || (state == ST_SRC) || (state == ST_BODY);
    assign take     = start || (in_valid && in_frame);

    rx_daf_capture #(.W(W), .HDR(2 * NOCT)) u_cap (
        .clk(clk), .rst_n(rst_n), .take(take), .start(start), .eof(in_eof),
        .data(in_data), .err_in(err_in), .da(da), .sa(sa), .cnt(cnt), .err_q(err_q)
    );

    rx_daf_hash #(.W(W), .NOCT(NOCT), .IDX_W(HASH_IDX_W), .CW(CW)) u_hash (
        .clk(clk), .rst_n(rst_n), .take(take), .start(start), .cnt(cnt),
        .data(in_data), .table_hi(hash_hi), .table_lo(hash_lo), .hit(hash_hit)
    );

    rx_daf_decide #(.AW(AW), .CW(CW), .NOCT(NOCT)) u_dec (
        .cfg(cfg), .da(da), .sa(sa), .st_hi(station_hi), .st_lo(station_lo),
        .sa_ref(sa_ref), .cnt(cnt), .err(err_q), .hash_hit(hash_hit), .accept(decide)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        if (start) begin
            nxt = in_eof ? ST_EVAL : ST_DEST;
        end else begin
            unique case (state)
                ST_DEST: if (in_valid) begin
                    if (in_eof)              nxt = ST_EVAL;
                    else if (cnt == LAST_DA) nxt = ST_SRC;
                end
                ST_SRC: if (in_valid) begin
                    if (in_eof)              nxt = ST_EVAL;
                    else if (cnt == LAST_SA) nxt = ST_BODY;
                end
                ST_BODY: if (in_valid && in_eof) nxt = ST_EVAL;
                ST_EVAL: nxt = ST_HOLD;
                ST_IDLE, ST_HOLD: nxt = state;
                default: nxt = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                accept_q <= 1'b0;
        else if (start)            accept_q <= 1'b0;
        else if (state == ST_EVAL) accept_q <= decide;
    end

    // Outputs
    always_comb begin
        dec_valid  = (state == ST_EVAL);
        dec_accept = dec_valid ? decide : accept_q;
    end

    // R2
    pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid && !(in_valid && in_sof && in_eof) |=> !dec_valid);
    // R2
    eof_before_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> $past(in_valid && in_eof));
    // R2
    verdict_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid && !$past(dec_valid) && !$past(in_valid && in_sof) |-> $stable(dec_accept));
    // R3
    pass_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid && cfg_pass_all |-> dec_accept);
    // R4
    crc_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid && !cfg_pass_all && !cfg_pass_crc && err_q.crc |-> !dec_accept);
    // R9
    short_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid && !cfg_pass_all && (cnt < CW'(NOCT)) |-> !dec_accept);
    // R10
    hold_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD) && !(in_valid && in_sof) |=> (state == ST_HOLD));

endmodule

// File: tb/rx_da_filter_tb.sv
`timescale 1ns/1ps
module rx_da_filter_tb;

    logic clk = 1'b0;
    logic rst_n;
    logic in_valid, in_sof, in_eof, in_crc_err, in_len_err, in_range_err;
    logic [7:0] in_data;
    logic cfg_pass_all, cfg_pass_crc, cfg_pass_len, cfg_pass_range;
    logic cfg_ucast_en, cfg_da_match_en, cfg_mcast_en, cfg_hash_en, cfg_bcast_en;
    logic cfg_sa_en, cfg_sa_invert;
    logic [23:0] station_hi, station_lo;
    logic [31:0] hash_hi, hash_lo;
    logic [47:0] sa_ref;
    logic dec_valid, dec_accept;

    int checks = 0;
    int errors = 0;
    int pulses = 0;
    logic [7:0] fb [0:31];

    always #2.5 clk = ~clk;

    rx_da_filter u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_sof(in_sof), .in_eof(in_eof), .in_crc_err(in_crc_err),
        .in_len_err(in_len_err), .in_range_err(in_range_err),
        .cfg_pass_all(cfg_pass_all), .cfg_pass_crc(cfg_pass_crc),
        .cfg_pass_len(cfg_pass_len), .cfg_pass_range(cfg_pass_range),
        .cfg_ucast_en(cfg_ucast_en), .cfg_da_match_en(cfg_da_match_en),
        .cfg_mcast_en(cfg_mcast_en), .cfg_hash_en(cfg_hash_en),
        .cfg_bcast_en(cfg_bcast_en), .cfg_sa_en(cfg_sa_en),
        .cfg_sa_invert(cfg_sa_invert), .station_hi(station_hi),
        .station_lo(station_lo), .hash_hi(hash_hi), .hash_lo(hash_lo),
        .sa_ref(sa_ref), .dec_valid(dec_valid), .dec_accept(dec_accept)
    );

    always @(negedge clk) if (rst_n && dec_valid) pulses++;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic idle_in();
        in_valid = 0; in_sof = 0; in_eof = 0;
        in_crc_err = 0; in_len_err = 0; in_range_err = 0; in_data = 8'h00;
    endtask

    task automatic defaults();
        cfg_pass_all = 0; cfg_pass_crc = 0; cfg_pass_len = 0; cfg_pass_range = 0;
        cfg_ucast_en = 1; cfg_da_match_en = 1; cfg_mcast_en = 1; cfg_hash_en = 0;
        cfg_bcast_en = 1; cfg_sa_en = 0; cfg_sa_invert = 0;
        station_hi = 24'h021122; station_lo = 24'h334455;
        hash_hi = 0; hash_lo = 0; sa_ref = 48'h0A0B0C0D0E0F;
    endtask

    task automatic load_hdr(input logic [47:0] da, input logic [47:0] sa);
        for (int i = 0; i < 6; i++) begin
            fb[i]   = da[47-8*i -: 8];
            fb[i+6] = sa[47-8*i -: 8];
        end
        for (int i = 12; i < 32; i++) fb[i] = 8'(i * 7);
    endtask

    function automatic logic [5:0] ref_idx(input logic [47:0] da);
        logic [31:0] r = 32'hFFFFFFFF;
        logic f;
        for (int o = 0; o < 6; o++)
            for (int b = 0; b < 8; b++) begin
                f = r[0] ^ da[47 - 8*o - 7 + b];
                r = {1'b0, r[31:1]};
                if (f) r = r ^ 32'hEDB88320;
            end
        return r[31:26];
    endfunction

    task automatic run_frame(input int n, input bit ce, input bit le, input bit re,
                             input bit gaps, input bit exp, input string tag);
        logic v1, a1, v2, a2;
        for (int i = 0; i < n; i++) begin
            if (gaps && (i % 3 == 1)) begin @(negedge clk); idle_in(); end
            @(negedge clk);
            in_valid = 1; in_data = fb[i]; in_sof = (i == 0); in_eof = (i == n-1);
            in_crc_err = (i == n-1) && ce; in_len_err = (i == n-1) && le;
            in_range_err = (i == n-1) && re;
        end
        @(negedge clk); idle_in(); v1 = dec_valid; a1 = dec_accept;
        @(negedge clk); v2 = dec_valid; a2 = dec_accept;
        chk(v1 == 1'b1, {tag, " R2 strobe"}, v1, 1);
        chk(a1 == exp,  {tag, " verdict"}, a1, exp);
        chk(v2 == 1'b0, {tag, " R2 single pulse"}, v2, 0);
        chk(a2 == exp,  {tag, " R2 held"}, a2, exp);
    endtask

    task automatic t_reset();
        chk(dec_valid == 0, "R1 valid", dec_valid, 0);
        chk(dec_accept == 0, "R1 accept", dec_accept, 0);
    endtask

    task automatic t_bcast();
        defaults(); load_hdr(48'hFFFFFFFFFFFF, sa_ref);
        run_frame(16, 0, 0, 0, 0, 1, "R5 bcast on");
        cfg_bcast_en = 0;
        run_frame(16, 0, 0, 0, 0, 0, "R5 bcast off");
    endtask

    task automatic t_ucast();
        defaults(); load_hdr(48'h021122334455, sa_ref);
        run_frame(16, 0, 0, 0, 0, 1, "R6 match");
        load_hdr(48'h021122334456, sa_ref);
        run_frame(16, 0, 0, 0, 0, 0, "R6 mismatch");
        cfg_da_match_en = 0;
        run_frame(16, 0, 0, 0, 0, 1, "R6 promiscuous");
        cfg_ucast_en = 0;
        run_frame(16, 0, 0, 0, 0, 0, "R6 disabled");
    endtask

    task automatic t_mcast();
        logic [47:0] m = 48'h01005E000001;
        logic [5:0] k;
        logic [63:0] tbl;
        defaults(); load_hdr(m, sa_ref); cfg_hash_en = 1;
        k = ref_idx(m);
        tbl = 64'd1 << k;
        hash_hi = tbl[63:32]; hash_lo = tbl[31:0];
        run_frame(16, 0, 0, 0, 0, 1, "R7 hash hit");
        tbl = ~tbl;
        hash_hi = tbl[63:32]; hash_lo = tbl[31:0];
        run_frame(16, 0, 0, 0, 0, 0, "R7 hash miss");
        cfg_hash_en = 0;
        run_frame(16, 0, 0, 0, 0, 1, "R7 no hash");
        cfg_mcast_en = 0;
        run_frame(16, 0, 0, 0, 0, 0, "R7 disabled");
    endtask

    task automatic t_errors();
        defaults(); load_hdr(48'h021122334455, sa_ref);
        run_frame(16, 1, 0, 0, 0, 0, "R4 crc drop");
        cfg_pass_crc = 1;
        run_frame(16, 1, 0, 0, 0, 1, "R4 crc pass");
        run_frame(16, 0, 1, 0, 0, 0, "R4 len drop");
        cfg_pass_len = 1;
        run_frame(16, 0, 1, 0, 0, 1, "R4 len pass");
        run_frame(16, 0, 0, 1, 0, 0, "R4 range drop");
        cfg_pass_range = 1;
        run_frame(16, 0, 0, 1, 0, 1, "R4 range pass");
    endtask

    task automatic t_pass_all();
        defaults(); cfg_pass_all = 1; cfg_ucast_en = 0;
        load_hdr(48'h021122334499, sa_ref);
        run_frame(16, 1, 1, 1, 0, 1, "R3 errors");
        run_frame(3, 0, 0, 0, 0, 1, "R3 short");
    endtask

    task automatic t_short();
        defaults(); load_hdr(48'h021122334455, sa_ref);
        run_frame(5, 0, 0, 0, 0, 0, "R9 five bytes");
        run_frame(6, 0, 0, 0, 0, 1, "R9 six bytes");
    endtask

    task automatic t_sa();
        defaults(); cfg_sa_en = 1;
        load_hdr(48'h021122334455, 48'h0A0B0C0D0E0F);
        run_frame(16, 0, 0, 0, 0, 1, "R8 sa match");
        load_hdr(48'h021122334455, 48'h0A0B0C0D0E00);
        run_frame(16, 0, 0, 0, 0, 0, "R8 sa differ");
        cfg_sa_invert = 1;
        run_frame(16, 0, 0, 0, 0, 1, "R8 inverted differ");
        load_hdr(48'h021122334455, 48'h0A0B0C0D0E0F);
        run_frame(16, 0, 0, 0, 0, 0, "R8 inverted match");
        run_frame(8, 0, 0, 0, 0, 1, "R8 short source");
    endtask

    task automatic t_framing();
        int p0;
        defaults(); load_hdr(48'h021122334455, sa_ref);
        run_frame(16, 0, 0, 0, 1, 1, "R10 gaps");
        // stray end byte while holding
        p0 = pulses;
        @(negedge clk); in_valid = 1; in_eof = 1; in_data = 8'h55;
        @(negedge clk); idle_in();
        @(negedge clk);
        chk(pulses == p0, "R10 stray eof pulses", pulses - p0, 0);
        chk(dec_accept == 1, "R10 stray eof verdict", dec_accept, 1);
        // start byte clears the held verdict
        @(negedge clk); in_valid = 1; in_sof = 1; in_data = 8'h02;
        @(negedge clk); idle_in();
        chk(dec_accept == 0, "R2 cleared by sof", dec_accept, 0);
        // abandoned frame then a full one: one decision only
        p0 = pulses;
        for (int i = 1; i < 4; i++) begin
            @(negedge clk); in_valid = 1; in_data = fb[i];
        end
        @(negedge clk); idle_in();
        run_frame(16, 0, 0, 0, 0, 1, "R10 restart");
        chk(pulses - p0 == 1, "R10 restart pulses", pulses - p0, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle_in(); defaults();
        rst_n = 0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_bcast();
        t_ucast();
        t_mcast();
        t_errors();
        t_pass_all();
        t_short();
        t_sa();
        t_framing();
        repeat (3) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule